// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment-relative offset into a linear address. It has two translation modes. In the 16-bit legacy mode, a 16-bit segment value is moved up by four bit positions and a 16-bit offset is added to it, which gives a 20-bit physical address. In protected mode, a 32-bit offset is added to the 32-bit base of a cached segment descriptor. In that mode the access is also checked against the descriptor's present bit, its 20-bit limit, which is scaled by a granularity bit, and a 16-bit bound that applies to small stack segments.

The address pipeline places the unit between the effective-address adder and the paging stage. Each request gives the mode, the descriptor fields already held for the selected segment, the offset and the access type (size in bytes and whether it is a stack access). One cycle later the unit presents either a valid linear address or exactly one fault flag. Paging and privilege checks are done by other blocks.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `lin_addr_o` is 0 and `valid_o`, `fault_limit_o` and `fault_np_o` are all low.
- R2: A cycle with `req_i` low produces, one clock later, zero on `lin_addr_o` and all three flags low.
- R3: Legacy mode (`mode_prot_i`=0) produces `((desc_base_i[15:0] << 4) + offset_i[15:0]) mod 2^20`. Bits 31..20 of the output are zero. For example, segment 1100h with offset 0450h gives 11450h.
- R4: In legacy mode no fault is ever raised. The present bit, limit, granularity, size bit, access size and stack flag have no effect, and `valid_o` is high.
- R5: Protected mode (`mode_prot_i`=1) with a present descriptor and an in-bound access produces `valid_o`=1 and `lin_addr_o = (desc_base_i + offset_i) mod 2^32`.
- R6: In protected mode, `desc_present_i`=0 raises `fault_np_o` only. This fault takes priority over every limit check, and the address output is 0.
- R7: The access end is `offset_i + bytes - 1`, computed without truncation. `acc_size_i` encodes 0=1, 1=2, 2=4 and 3=8 bytes. With `desc_gran_i`=0 the limit counts bytes, so the access faults (`fault_limit_o`) when the end exceeds `desc_limit_i`.
- R8: With `desc_gran_i`=1 the effective limit is `(desc_limit_i << 12) | FFFh`. An end past that limit, or past 2^32-1, raises `fault_limit_o`.
- R9: For a stack access (`acc_stack_i`=1) with `desc_big_i`=0, an end above FFFFh also raises `fault_limit_o`. With `desc_big_i`=1, or for a non-stack access, this extra bound does not apply.
- R10: Results appear exactly one clock after the request. `valid_o`, `fault_limit_o` and `fault_np_o` are never high together, and `lin_addr_o` is 0 whenever a fault flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request this cycle |
| mode_prot_i | input | 1 | 1 = protected mode, 0 = 16-bit legacy mode |
| desc_base_i | input | 32 | Descriptor base; in legacy mode bits 15..0 hold the segment value |
| desc_limit_i | input | 20 | Descriptor limit |
| desc_gran_i | input | 1 | Limit granularity: 0 = bytes, 1 = 4 KB units |
| desc_present_i | input | 1 | Descriptor present bit |
| desc_big_i | input | 1 | Size bit: 1 = 32-bit stack bound, 0 = 16-bit stack bound |
| offset_i | input | 32 | Segment-relative offset |
| acc_size_i | input | 2 | Access size code (0=1, 1=2, 2=4, 3=8 bytes) |
| acc_stack_i | input | 1 | Access is a stack reference |
| lin_addr_o | output | 32 | Translated address |
| valid_o | output | 1 | Address is valid |
| fault_limit_o | output | 1 | Limit or stack-bound fault |
| fault_np_o | output | 1 | Not-present fault |

## Verification
The bench places offsets exactly on and one byte past the effective limit for both granularity settings, and for multi-byte accesses. A design that compares only the first byte, or that forgets the FFFh fill in 4 KB mode, would accept or reject these accesses one byte off. It drives legacy sums that cross the 1 MB boundary and protected sums that cross 4 GB. A design that failed to wrap, or that left carries in the upper bits, would show a wrong address. It also drives a descriptor that is not present together with an out-of-limit offset, and an access in 4 KB mode whose end carries past 32 bits. A design with the wrong fault priority, or with a truncated end adder, would raise the wrong flag or no flag.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Access size codes: byte count is 1 << code
  typedef enum logic [1:0] {
    ACC_B1 = 2'd0,
    ACC_B2 = 2'd1,
    ACC_B4 = 2'd2,
    ACC_B8 = 2'd3
  } acc_size_e;

  // Outcome of one translation
  typedef struct packed {
    logic ok;
    logic lim;
    logic np;
  } xl_status_t;

  // Bytes covered beyond the first one
  function automatic logic [3:0] acc_extra_bytes(input logic [1:0] code);
    logic [3:0] r;
    case (acc_size_e'(code))
      ACC_B1:  r = 4'd0;
      ACC_B2:  r = 4'd1;
      ACC_B4:  r = 4'd3;
      default: r = 4'd7;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seg_legacy_path.sv
module seg_legacy_path #(
  parameter int SEG_W = 16,
  parameter int SH    = 4,
  parameter int OUT_W = 32
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [SEG_W-1:0] off_i,
  output logic [OUT_W-1:0] addr_o
);
  localparam int PW = SEG_W + SH;

  // Segment moved up by SH bits plus offset, wrapping at 2^PW
  function automatic logic [PW-1:0] leg_phys(input logic [SEG_W-1:0] seg,
                                             input logic [SEG_W-1:0] off);
    return {seg, {SH{1'b0}}} + PW'(off);
  endfunction

  assign addr_o = OUT_W'(leg_phys(seg_i, off_i));

endmodule

// File: rtl/seg_prot_path.sv
module seg_prot_path #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] addr_o
);
  // Base plus offset modulo 2^AW
  function automatic logic [AW-1:0] lin_sum(input logic [AW-1:0] b,
                                            input logic [AW-1:0] o);
    return b + o;
  endfunction

  assign addr_o = lin_sum(base_i, off_i);

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 20,
  parameter int GS = 12,
  parameter int SB = 16
) (
  input  logic [AW-1:0] off_i,
  input  logic [1:0]    size_i,
  input  logic [LW-1:0] limit_i,
  input  logic          gran_i,
  input  logic          big_i,
  input  logic          stack_i,
  output logic          over_desc_o,
  output logic          over_stack_o
);
  localparam int EW = AW + 1;

  // Last byte touched, one extra bit so a carry past 2^AW is kept
  function automatic logic [EW-1:0] span_end(input logic [AW-1:0] off,
                                             input logic [1:0] sz);
    return {1'b0, off} + EW'(acc_extra_bytes(sz));
  endfunction

  // Highest offset allowed by the descriptor
  function automatic logic [AW-1:0] eff_limit(input logic [LW-1:0] lim,
                                              input logic g);
    logic [AW-1:0] r;
    if (g) r = AW'({lim, {GS{1'b1}}});
    else   r = AW'(lim);
    return r;
  endfunction

  logic [EW-1:0] end_w;
  logic [AW-1:0] lim_w;

  assign end_w        = span_end(off_i, size_i);
  assign lim_w        = eff_limit(limit_i, gran_i);
  assign over_desc_o  = end_w > {1'b0, lim_w};
  assign over_stack_o = stack_i && !big_i && (end_w > EW'({SB{1'b1}}));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 20,
  parameter int GS     = 12,
  parameter int LEG_W  = 16,
  parameter int LEG_SH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          mode_prot_i,
  input  logic [31:0]   desc_base_i,
  input  logic [19:0]   desc_limit_i,
  input  logic          desc_gran_i,
  input  logic          desc_present_i,
  input  logic          desc_big_i,
  input  logic [31:0]   offset_i,
  input  logic [1:0]    acc_size_i,
  input  logic          acc_stack_i,
  output logic [31:0]   lin_addr_o,
  output logic          valid_o,
  output logic          fault_limit_o,
  output logic          fault_np_o
);
  // Named internal events, used by the checker
  logic [AW-1:0] w_leg_addr;
  logic [AW-1:0] w_prot_addr;
  logic          w_over_desc;
  logic          w_over_stack;
  logic          w_over_any;
  xl_status_t    w_status;
  logic [AW-1:0] w_addr_nxt;

  seg_legacy_path #(.SEG_W(LEG_W), .SH(LEG_SH), .OUT_W(AW)) u_leg (
    .seg_i  (desc_base_i[LEG_W-1:0]),
    .off_i  (offset_i[LEG_W-1:0]),
    .addr_o (w_leg_addr)
  );

  seg_prot_path #(.AW(AW)) u_prot (
    .base_i (desc_base_i),
    .off_i  (offset_i),
    .addr_o (w_prot_addr)
  );

  seg_limit_check #(.AW(AW), .LW(LW), .GS(GS), .SB(LEG_W)) u_lim (
    .off_i        (offset_i),
    .size_i       (acc_size_i),
    .limit_i      (desc_limit_i),
    .gran_i       (desc_gran_i),
    .big_i        (desc_big_i),
    .stack_i      (acc_stack_i),
    .over_desc_o  (w_over_desc),
    .over_stack_o (w_over_stack)
  );

  assign w_over_any = w_over_desc || w_over_stack;

  always_comb begin
    w_status = '0;
    if (req_i) begin
      if (!mode_prot_i)          w_status.ok  = 1'b1;
      else if (!desc_present_i)  w_status.np  = 1'b1;
      else if (w_over_any)       w_status.lim = 1'b1;
      else                       w_status.ok  = 1'b1;
    end
  end

  always_comb begin
    w_addr_nxt = '0;
    if (w_status.ok) w_addr_nxt = mode_prot_i ? w_prot_addr : w_leg_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_addr_o    <= '0;
      valid_o       <= 1'b0;
      fault_limit_o <= 1'b0;
      fault_np_o    <= 1'b0;
    end else begin
      lin_addr_o    <= w_addr_nxt;
      valid_o       <= w_status.ok;
      fault_limit_o <= w_status.lim;
      fault_np_o    <= w_status.np;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW = 32,
  parameter int PW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          mode_prot_i,
  input logic          desc_present_i,
  input logic          over_any,
  input logic [AW-1:0] lin_addr_o,
  input logic          valid_o,
  input logic          fault_limit_o,
  input logic          fault_np_o
);
  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_o, fault_limit_o, fault_np_o})); // R10

  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_limit_o || fault_np_o) |-> lin_addr_o == '0); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!valid_o && !fault_limit_o && !fault_np_o && lin_addr_o == '0)); // R2

  AST_LEGACY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !mode_prot_i) |=> valid_o); // R4

  AST_LEGACY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !mode_prot_i) |=> lin_addr_o[AW-1:PW] == '0); // R3

  AST_NP_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_prot_i && !desc_present_i) |=> fault_np_o); // R6

  AST_LIMIT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_prot_i && desc_present_i && over_any) |=> fault_limit_o); // R7

  AST_INBOUND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_prot_i && desc_present_i && !over_any) |=> valid_o); // R5

endmodule

bind seg_xlate_unit seg_xlate_chk #(.AW(AW), .PW(LEG_W + LEG_SH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_i          (req_i),
  .mode_prot_i    (mode_prot_i),
  .desc_present_i (desc_present_i),
  .over_any       (w_over_any),
  .lin_addr_o     (lin_addr_o),
  .valid_o        (valid_o),
  .fault_limit_o  (fault_limit_o),
  .fault_np_o     (fault_np_o)
);

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        mode_prot_i = 1'b0;
  logic [31:0] desc_base_i = '0;
  logic [19:0] desc_limit_i = '0;
  logic        desc_gran_i = 1'b0;
  logic        desc_present_i = 1'b0;
  logic        desc_big_i = 1'b0;
  logic [31:0] offset_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic        acc_stack_i = 1'b0;
  logic [31:0] lin_addr_o;
  logic        valid_o, fault_limit_o, fault_np_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Expected result queue: {addr, valid, lim, np}
  typedef struct { longint unsigned addr; bit v; bit l; bit n; string tag; } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  seg_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_prot_i(mode_prot_i),
    .desc_base_i(desc_base_i), .desc_limit_i(desc_limit_i),
    .desc_gran_i(desc_gran_i), .desc_present_i(desc_present_i),
    .desc_big_i(desc_big_i), .offset_i(offset_i), .acc_size_i(acc_size_i),
    .acc_stack_i(acc_stack_i), .lin_addr_o(lin_addr_o), .valid_o(valid_o),
    .fault_limit_o(fault_limit_o), .fault_np_o(fault_np_o)
  );

  function automatic exp_t model(bit rq, bit pm, longint unsigned base,
                                 longint unsigned lim, bit g, bit pr, bit bg,
                                 longint unsigned off, int sz, bit st, string tag);
    exp_t e;
    longint unsigned last, top;
    e.addr = 0; e.v = 0; e.l = 0; e.n = 0; e.tag = tag;
    if (!rq) return e;
    if (!pm) begin
      e.v = 1;
      e.addr = ((base % 65536) * 16 + (off % 65536)) % 1048576;
      return e;
    end
    if (!pr) begin e.n = 1; return e; end
    last = off + (64'd1 << sz) - 1;
    top = g ? lim * 4096 + 4095 : lim;
    if (last > top || (st && !bg && last > 65535)) begin e.l = 1; return e; end
    e.v = 1;
    e.addr = (base + off) % 64'h1_0000_0000;
    return e;
  endfunction

  function automatic void compare(exp_t e);
    checks++;
    if (lin_addr_o !== e.addr[31:0] || valid_o !== e.v ||
        fault_limit_o !== e.l || fault_np_o !== e.n) begin
      failures++;
      $display("FAIL %s: got addr=%h v=%0b lim=%0b np=%0b, expected addr=%h v=%0b lim=%0b np=%0b",
               e.tag, lin_addr_o, valid_o, fault_limit_o, fault_np_o,
               e.addr[31:0], e.v, e.l, e.n);
    end
    if ((valid_o + fault_limit_o + fault_np_o) > 1) begin
      failures++;
      $display("FAIL R10: flags not exclusive v=%0b lim=%0b np=%0b, expected at most one",
               valid_o, fault_limit_o, fault_np_o);
    end
  endfunction

  // Apply one cycle of stimulus, then check the registered result
  task automatic drive(bit rq, bit pm, logic [31:0] base, logic [19:0] lim,
                       bit g, bit pr, bit bg, logic [31:0] off, int sz,
                       bit st, string tag);
    req_i = rq; mode_prot_i = pm; desc_base_i = base; desc_limit_i = lim;
    desc_gran_i = g; desc_present_i = pr; desc_big_i = bg; offset_i = off;
    acc_size_i = 2'(sz); acc_stack_i = st;
    expq.push_back(model(rq, pm, base, lim, g, pr, bg, off, sz, st, tag));
    @(posedge clk); #1;
    compare(expq.pop_front());
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t z;
    z = model(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    repeat (3) @(posedge clk);
    #1; compare(z);                      // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    #1; compare(z);                      // R1 after release
    @(negedge clk);

    // R2 idle even with busy-looking inputs
    drive(0, 1, 32'h1234_0000, 20'h0, 0, 0, 0, 32'hFFFF_FFFF, 3, 1, "R2");
    drive(0, 0, 32'h0000_1100, 20'h0, 0, 1, 0, 32'h450, 0, 0, "R2");

    // R3 legacy arithmetic and wrap
    drive(1, 0, 32'h0000_1100, 20'h0, 0, 1, 0, 32'h0000_0450, 0, 0, "R3");
    drive(1, 0, 32'hABCD_FFFF, 20'h0, 0, 1, 0, 32'h0000_0010, 0, 0, "R3");
    drive(1, 0, 32'h0000_F000, 20'h0, 0, 1, 0, 32'h5555_FFFF, 0, 0, "R3");
    drive(1, 0, 32'h0000_1A2B, 20'h0, 0, 1, 0, 32'h0000_019A, 1, 0, "R3");

    // R4 legacy ignores descriptor checks
    drive(1, 0, 32'h0000_3911, 20'h0, 0, 0, 0, 32'h0000_FFFF, 3, 1, "R4");
    drive(1, 0, 32'h0000_2591, 20'h0, 1, 0, 1, 32'h0000_10B5, 2, 1, "R4");

    // R5 protected sums, including 4 GB wrap
    drive(1, 1, 32'h1000_0000, 20'hFFFFF, 1, 1, 1, 32'h0000_1234, 2, 0, "R5");
    drive(1, 1, 32'hFFFF_F000, 20'hFFFFF, 1, 1, 1, 32'h0000_2000, 0, 0, "R5");

    // R6 not-present wins over limit
    drive(1, 1, 32'h0000_0000, 20'h0, 0, 0, 0, 32'h0001_0000, 3, 1, "R6");
    drive(1, 1, 32'h0000_0000, 20'hFFFFF, 1, 0, 1, 32'h0, 0, 0, "R6");

    // R7 byte granularity boundaries
    drive(1, 1, 32'h0002_0000, 20'h000FF, 0, 1, 1, 32'hFF, 0, 0, "R7");
    drive(1, 1, 32'h0002_0000, 20'h000FF, 0, 1, 1, 32'hFF, 1, 0, "R7");
    drive(1, 1, 32'h0002_0000, 20'h000FF, 0, 1, 1, 32'hFC, 2, 0, "R7");
    drive(1, 1, 32'h0002_0000, 20'h000FF, 0, 1, 1, 32'hFD, 2, 0, "R7");
    drive(1, 1, 32'h0002_0000, 20'h000FF, 0, 1, 1, 32'h100, 0, 0, "R7");
    drive(1, 1, 32'h0002_0000, 20'h00000, 0, 1, 1, 32'h0, 0, 0, "R7");

    // R8 4 KB granularity boundaries
    drive(1, 1, 32'h0040_0000, 20'h00001, 1, 1, 1, 32'h1FFF, 0, 0, "R8");
    drive(1, 1, 32'h0040_0000, 20'h00001, 1, 1, 1, 32'h2000, 0, 0, "R8");
    drive(1, 1, 32'h0040_0000, 20'h00001, 1, 1, 1, 32'h1FF8, 3, 0, "R8");
    drive(1, 1, 32'h0040_0000, 20'h00001, 1, 1, 1, 32'h1FF9, 3, 0, "R8");
    drive(1, 1, 32'h0000_0000, 20'hFFFFF, 1, 1, 1, 32'hFFFF_FFFF, 0, 0, "R8");
    drive(1, 1, 32'h0000_0000, 20'hFFFFF, 1, 1, 1, 32'hFFFF_FFFE, 2, 0, "R8");

    // R9 small stack bound
    drive(1, 1, 32'h0000_8000, 20'hFFFFF, 1, 1, 0, 32'hFFFF, 0, 1, "R9");
    drive(1, 1, 32'h0000_8000, 20'hFFFFF, 1, 1, 0, 32'hFFFE, 1, 1, "R9");
    drive(1, 1, 32'h0000_8000, 20'hFFFFF, 1, 1, 0, 32'hFFFF, 1, 1, "R9");
    drive(1, 1, 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 32'h1_0000, 2, 1, "R9");
    drive(1, 1, 32'h0000_8000, 20'hFFFFF, 1, 1, 0, 32'h1_0000, 2, 0, "R9");

    // R10 mixed traffic, back-to-back and with gaps
    for (int i = 0; i < 400; i++) begin
      logic [19:0] lim;
      logic [31:0] off;
      bit g;
      lim = 20'($urandom);
      g = 1'($urandom);
      if ($urandom % 2 == 0) lim = lim & 20'h000FF;
      off = g ? {lim, 12'hFFF} : {12'h0, lim};
      off = off + 32'($urandom % 16) - 32'd8;
      if ($urandom % 4 == 0) off = $urandom;
      drive(1'($urandom % 5 != 0), 1'($urandom % 4 != 0), $urandom, lim, g,
            1'($urandom % 6 != 0), 1'($urandom), off, int'($urandom % 4),
            1'($urandom), "R10");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule